// File: doc/BRIEF.md
# Expanded-Memory Page Mapper

This block translates CPU addresses on a 24-bit bus that land inside one of thirty-two 16 KB windows into physical DRAM addresses. Each window is backed by a page entry that holds a 10-bit physical page number and an enable flag. Software programs the entries through three byte-wide I/O ports: an entry pointer, the low page byte, and a high byte that carries the top page bits and the enable flag. The ports can sit at one of two base addresses.

There are two window regions. Twenty-four windows tile the conventional area above 256 KB, and eight more start after a gap that the video and option-ROM ranges occupy. Translation applies only when a global enable from a control register and the entry's own enable flag are both set. Otherwise the address passes through unchanged. When a translated address lands at or above the installed memory size, the block raises a miss flag, and the memory side then reads 0xFF and drops writes.

Top module: `ems_page_mapper`

## Requirements
- R1: After reset every entry holds low byte 0xFF and high byte 0x03, the pointer holds 0x00, and no address is translated.
- R2: With `ctl_port_en` high, the ports sit at base 0x208 when `ctl_base_sel` is 0 and at 0x218 when it is 1. Base+0 is the low page byte, base+1 the high byte and base+2 the pointer.
- R3: When `ctl_port_en` is low, or the address is not one of the three ports at the selected base, reads return 0xFF and writes change nothing.
- R4: A write to base+2 stores all 8 bits of the pointer, and reading base+2 returns them. Pointer bits 4:0 pick the entry that base+0 and base+1 reach.
- R5: The low and high bytes of each entry are stored in full and read back unchanged. A write to one entry leaves every other entry as it was.
- R6: A write to base+1 while pointer bit 7 is set advances pointer bits 4:0 by one, wrapping from 31 to 0, and leaves bits 7:5 unchanged. Writes to base+0, and any write while bit 7 is clear, leave the pointer unchanged.
- R7: Entry n < 24 covers the window at 0x40000 + n×0x4000. Entry n ≥ 24 covers the window at 0xD0000 + (n−24)×0x4000. Addresses in 0xA0000–0xCFFFF and outside both regions never hit.
- R8: When `ctl_xlat_en` is high and the window's entry has high-byte bit 7 set, `phys_addr` = {high[1:0], low[7:0], cpu_addr[13:0]} and `win_hit` is 1.
- R9: In every other case, `phys_addr` equals `cpu_addr` and `win_hit` is 0.
- R10: `mem_miss` is 1 exactly when `win_hit` is 1 and `phys_addr` ≥ MEM_LIMIT (default 0x800000).
- R11: While `io_rd` is low, `io_rdata` is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_rd | input | 1 | I/O read strobe |
| io_rdata | output | 8 | I/O read data, combinational |
| ctl_port_en | input | 1 | Enables the page I/O ports |
| ctl_base_sel | input | 1 | Selects the port base: 0 gives 0x208, 1 gives 0x218 |
| ctl_xlat_en | input | 1 | Global translation enable |
| cpu_addr | input | 24 | CPU address to translate |
| phys_addr | output | 24 | Translated or passed-through address |
| win_hit | output | 1 | Address translated through an enabled entry |
| mem_miss | output | 1 | Translated address lies beyond installed memory |

## Verification
The hardest case to reach is the pointer wrap during auto-increment. The pointer must hold index 31 with bit 7 set at the moment a high-byte write lands, and the bits above the index must survive the step. The bench writes 0x9F to the pointer and then writes the high byte. It reads the pointer back through the port and expects 0x80. It then checks that the entry just written at index 31 is the one that now translates in the last upper window. The miss boundary is reached by programming a page number whose base equals the memory limit exactly, and the page just below it is checked as well.

// File: rtl/ems_pkg.sv
package ems_pkg;

  typedef enum logic [1:0] {
    PSEL_NONE = 2'd0,
    PSEL_LO   = 2'd1,
    PSEL_HI   = 2'd2,
    PSEL_PTR  = 2'd3
  } port_sel_e;

  typedef struct packed {
    logic [7:0] hi;
    logic [7:0] lo;
  } page_ent_t;

  localparam int EN_BIT   = 7;
  localparam int STEP_BIT = 7;
  localparam logic [7:0] RESET_LO = 8'hFF;
  localparam logic [7:0] RESET_HI = 8'h03;
  localparam logic [7:0] IDLE_BYTE = 8'hFF;

endpackage

// File: rtl/ems_port_decode.sv
module ems_port_decode
  import ems_pkg::*;
#(
  parameter int IO_W = 16,
  parameter logic [15:0] BASE_A = 16'h0208,
  parameter logic [15:0] BASE_B = 16'h0218
) (
  input  logic [IO_W-1:0] io_addr,
  input  logic            port_en,
  input  logic            base_sel,
  output port_sel_e       sel
);

  function automatic port_sel_e decode(input logic [IO_W-1:0] a,
                                       input logic [IO_W-1:0] base);
    if (a == base)                 return PSEL_LO;
    if (a == base + IO_W'(1))      return PSEL_HI;
    if (a == base + IO_W'(2))      return PSEL_PTR;
    return PSEL_NONE;
  endfunction

  logic [IO_W-1:0] base;
  assign base = base_sel ? IO_W'(BASE_B) : IO_W'(BASE_A);

  always_comb begin
    sel = PSEL_NONE;
    if (port_en) sel = decode(io_addr, base);
  end

endmodule

// File: rtl/ems_page_file.sv
module ems_page_file
  import ems_pkg::*;
#(
  parameter int NPAGES = 32,
  parameter int PN_W   = 10,
  localparam int IDX_W = $clog2(NPAGES),
  localparam int HI_PN = PN_W - 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  port_sel_e        sel,
  input  logic             io_wr,
  input  logic [7:0]       io_wdata,
  input  logic [IDX_W-1:0] look_idx,
  output logic [7:0]       ptr_q,
  output page_ent_t        cur_ent,
  output logic [PN_W-1:0]  look_pn,
  output logic             look_en,
  output logic             ptr_step
);

  page_ent_t ents [NPAGES];
  logic [IDX_W-1:0] cur_idx;

  assign cur_idx  = ptr_q[IDX_W-1:0];
  assign ptr_step = io_wr && (sel == PSEL_HI) && ptr_q[STEP_BIT];

  function automatic logic [7:0] bump(input logic [7:0] p);
    logic [7:0] r;
    r = p;
    r[IDX_W-1:0] = p[IDX_W-1:0] + IDX_W'(1);
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)                               ptr_q <= 8'h00;
    else if (io_wr && sel == PSEL_PTR)        ptr_q <= io_wdata;
    else if (ptr_step)                        ptr_q <= bump(ptr_q);
  end

  for (genvar g = 0; g < NPAGES; g++) begin : g_ent
    logic sel_me;
    assign sel_me = io_wr && (cur_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ents[g].lo <= RESET_LO;
        ents[g].hi <= RESET_HI;
      end else if (sel_me && sel == PSEL_LO) begin
        ents[g].lo <= io_wdata;
      end else if (sel_me && sel == PSEL_HI) begin
        ents[g].hi <= io_wdata;
      end
    end
  end

  assign cur_ent = ents[cur_idx];

  page_ent_t look_ent;
  assign look_ent = ents[look_idx];
  assign look_pn  = {look_ent.hi[HI_PN-1:0], look_ent.lo};
  assign look_en  = look_ent.hi[EN_BIT];

  logic unused_hi;
  assign unused_hi = ^look_ent.hi[EN_BIT-1:HI_PN];

endmodule

// File: rtl/ems_xlate.sv
module ems_xlate #(
  parameter int ADDR_W     = 24,
  parameter int PAGE_SH    = 14,
  parameter int NPAGES     = 32,
  parameter int LOW_PAGES  = 24,
  parameter int LOW_FIRST  = 16,
  parameter int HIGH_FIRST = 52,
  parameter int MEM_LIMIT  = 24'h800000,
  localparam int IDX_W = $clog2(NPAGES),
  localparam int FR_W  = ADDR_W - PAGE_SH,
  localparam int HIGH_PAGES = NPAGES - LOW_PAGES
) (
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              xlat_en,
  input  logic [FR_W-1:0]   look_pn,
  input  logic              look_en,
  output logic [IDX_W-1:0]  look_idx,
  output logic [ADDR_W-1:0] phys_addr,
  output logic              win_hit,
  output logic              mem_miss
);

  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(MEM_LIMIT);

  function automatic logic in_span(input int fr, input int first, input int cnt);
    return (fr >= first) && (fr < first + cnt);
  endfunction

  function automatic logic [IDX_W-1:0] slot_of(input int fr);
    if (in_span(fr, LOW_FIRST, LOW_PAGES)) return IDX_W'(fr - LOW_FIRST);
    return IDX_W'(fr - HIGH_FIRST + LOW_PAGES);
  endfunction

  int   frame;
  logic in_win;

  always_comb begin
    frame    = int'(cpu_addr[ADDR_W-1:PAGE_SH]);
    in_win   = in_span(frame, LOW_FIRST, LOW_PAGES) ||
               in_span(frame, HIGH_FIRST, HIGH_PAGES);
    look_idx = slot_of(frame);
    win_hit  = in_win && xlat_en && look_en;
    phys_addr = win_hit ? {look_pn, cpu_addr[PAGE_SH-1:0]} : cpu_addr;
    mem_miss = win_hit && ({1'b0, phys_addr} >= LIMIT);
  end

endmodule

// File: rtl/ems_page_mapper.sv
module ems_page_mapper
  import ems_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int IO_W      = 16,
  parameter int NPAGES    = 32,
  parameter int PAGE_SH   = 14,
  parameter int MEM_LIMIT = 24'h800000,
  localparam int IDX_W = $clog2(NPAGES),
  localparam int PN_W  = ADDR_W - PAGE_SH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IO_W-1:0]   io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic [7:0]        io_rdata,
  input  logic              ctl_port_en,
  input  logic              ctl_base_sel,
  input  logic              ctl_xlat_en,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic [ADDR_W-1:0] phys_addr,
  output logic              win_hit,
  output logic              mem_miss
);

  port_sel_e        port_sel;
  logic [7:0]       ptr_q;
  page_ent_t        cur_ent;
  logic [IDX_W-1:0] look_idx;
  logic [PN_W-1:0]  look_pn;
  logic             look_en;
  logic             ptr_step;

  ems_port_decode #(.IO_W(IO_W)) u_dec (
    .io_addr (io_addr),
    .port_en (ctl_port_en),
    .base_sel(ctl_base_sel),
    .sel     (port_sel)
  );

  ems_page_file #(.NPAGES(NPAGES), .PN_W(PN_W)) u_file (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (port_sel),
    .io_wr   (io_wr),
    .io_wdata(io_wdata),
    .look_idx(look_idx),
    .ptr_q   (ptr_q),
    .cur_ent (cur_ent),
    .look_pn (look_pn),
    .look_en (look_en),
    .ptr_step(ptr_step)
  );

  ems_xlate #(
    .ADDR_W(ADDR_W), .PAGE_SH(PAGE_SH), .NPAGES(NPAGES), .MEM_LIMIT(MEM_LIMIT)
  ) u_xl (
    .cpu_addr (cpu_addr),
    .xlat_en  (ctl_xlat_en),
    .look_pn  (look_pn),
    .look_en  (look_en),
    .look_idx (look_idx),
    .phys_addr(phys_addr),
    .win_hit  (win_hit),
    .mem_miss (mem_miss)
  );

  always_comb begin
    io_rdata = IDLE_BYTE;
    if (io_rd) begin
      unique case (port_sel)
        PSEL_LO:  io_rdata = cur_ent.lo;
        PSEL_HI:  io_rdata = cur_ent.hi;
        PSEL_PTR: io_rdata = ptr_q;
        default:  io_rdata = IDLE_BYTE;
      endcase
    end
  end

endmodule

// File: rtl/ems_mapper_checks.sv
module ems_mapper_checks (
  input logic        clk,
  input logic        rst_n,
  input logic [23:0] cpu_addr,
  input logic [23:0] phys_addr,
  input logic        win_hit,
  input logic        mem_miss,
  input logic        ctl_xlat_en,
  input logic        ctl_port_en,
  input logic        io_rd,
  input logic [7:0]  io_rdata,
  input logic [7:0]  ptr_q,
  input logic        ptr_step
);

  p_pass_through_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !win_hit |-> phys_addr == cpu_addr);

  p_offset_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr[13:0] == cpu_addr[13:0]);

  p_hit_needs_global_r8: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> ctl_xlat_en);

  p_miss_needs_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_miss |-> win_hit);

  p_gap_never_hits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr >= 24'h0A0000 && cpu_addr < 24'h0D0000) |-> !win_hit);

  p_idle_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> io_rdata == 8'hFF);

  p_step_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_step |=> ptr_q[4:0] == $past(ptr_q[4:0]) + 5'd1);

  p_step_keeps_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_step |=> ptr_q[7:5] == $past(ptr_q[7:5]));

  p_ports_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_port_en |=> $stable(ptr_q));

endmodule

bind ems_page_mapper ems_mapper_checks u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_addr   (cpu_addr),
  .phys_addr  (phys_addr),
  .win_hit    (win_hit),
  .mem_miss   (mem_miss),
  .ctl_xlat_en(ctl_xlat_en),
  .ctl_port_en(ctl_port_en),
  .io_rd      (io_rd),
  .io_rdata   (io_rdata),
  .ptr_q      (ptr_q),
  .ptr_step   (ptr_step)
);

// File: tb/sim_ems_page_mapper.sv
module sim_ems_page_mapper;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = 16'h0;
  logic [7:0]  io_wdata = 8'h0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_rdata;
  logic        ctl_port_en = 1'b0;
  logic        ctl_base_sel = 1'b0;
  logic        ctl_xlat_en = 1'b0;
  logic [23:0] cpu_addr = 24'h0;
  logic [23:0] phys_addr;
  logic        win_hit;
  logic        mem_miss;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ems_page_mapper u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    io_rd = 1'b0;
  endtask

  task automatic probe(input logic [23:0] a, input string req,
                       input logic [23:0] exp_pa, input logic exp_hit, input logic exp_miss);
    @(negedge clk);
    cpu_addr = a;
    #1;
    check({req, " phys"}, 32'(phys_addr), 32'(exp_pa));
    check({req, " hit"},  32'(win_hit),   32'(exp_hit));
    check({req, " miss"}, 32'(mem_miss),  32'(exp_miss));
  endtask

  task automatic t_reset();
    logic [7:0] d;
    ctl_port_en = 1'b1; ctl_base_sel = 1'b0; ctl_xlat_en = 1'b1;
    io_read(16'h020A, d); check("R1 ptr", 32'(d), 32'h00);
    io_read(16'h0208, d); check("R1 lo", 32'(d), 32'hFF);
    io_read(16'h0209, d); check("R1 hi", 32'(d), 32'h03);
    io_write(16'h020A, 8'h1F);
    io_read(16'h0208, d); check("R1 lo31", 32'(d), 32'hFF);
    io_read(16'h0209, d); check("R1 hi31", 32'(d), 32'h03);
    probe(24'h04_0123, "R1 R9 disabled", 24'h04_0123, 1'b0, 1'b0);
  endtask

  task automatic t_ports();
    logic [7:0] d;
    ctl_base_sel = 1'b1;
    io_write(16'h021A, 8'h05);
    io_read(16'h021A, d); check("R2 R4 ptr at 0x21A", 32'(d), 32'h05);
    io_read(16'h020A, d); check("R3 other base", 32'(d), 32'hFF);
    io_read(16'h021B, d); check("R3 beyond ports", 32'(d), 32'hFF);
    ctl_base_sel = 1'b0;
    io_read(16'h020A, d); check("R2 ptr at 0x20A", 32'(d), 32'h05);
    io_write(16'h0218, 8'h44);
    io_read(16'h0208, d); check("R3 write other base", 32'(d), 32'hFF);
    ctl_port_en = 1'b0;
    io_read(16'h020A, d); check("R3 read disabled", 32'(d), 32'hFF);
    io_write(16'h020A, 8'h1C);
    ctl_port_en = 1'b1;
    io_read(16'h020A, d); check("R3 write disabled", 32'(d), 32'h05);
  endtask

  task automatic t_entry();
    logic [7:0] d;
    io_write(16'h020A, 8'h03);
    io_write(16'h0208, 8'h12);
    io_write(16'h0209, 8'h81);
    io_read(16'h0208, d); check("R5 lo", 32'(d), 32'h12);
    io_read(16'h0209, d); check("R5 hi", 32'(d), 32'h81);
    io_write(16'h020A, 8'h04);
    io_read(16'h0208, d); check("R5 neighbour lo", 32'(d), 32'hFF);
    io_read(16'h0209, d); check("R4 neighbour hi", 32'(d), 32'h03);
  endtask

  task automatic t_xlate();
    probe(24'h04_C0AB, "R8 entry3", 24'h44_80AB, 1'b1, 1'b0);
    ctl_xlat_en = 1'b0;
    probe(24'h04_C0AB, "R9 global off", 24'h04_C0AB, 1'b0, 1'b0);
    ctl_xlat_en = 1'b1;
    io_write(16'h020A, 8'h18);
    io_write(16'h0208, 8'h05);
    io_write(16'h0209, 8'h80);
    probe(24'h0D_0010, "R7 entry24", 24'h01_4010, 1'b1, 1'b0);
    io_write(16'h020A, 8'h1F);
    io_write(16'h0208, 8'h07);
    io_write(16'h0209, 8'h80);
    probe(24'h0E_C005, "R7 entry31", 24'h01_C005, 1'b1, 1'b0);
    probe(24'h0B_0000, "R7 gap", 24'h0B_0000, 1'b0, 1'b0);
    probe(24'h0F_0000, "R7 above", 24'h0F_0000, 1'b0, 1'b0);
    probe(24'h03_FFFF, "R7 below", 24'h03_FFFF, 1'b0, 1'b0);
  endtask

  task automatic t_miss();
    io_write(16'h020A, 8'h00);
    io_write(16'h0208, 8'h00);
    io_write(16'h0209, 8'h82);
    probe(24'h04_0001, "R10 at limit", 24'h80_0001, 1'b1, 1'b1);
    io_write(16'h0208, 8'hFF);
    io_write(16'h0209, 8'h81);
    probe(24'h04_3FFF, "R10 below limit", 24'h7F_FFFF, 1'b1, 1'b0);
  endtask

  task automatic t_autoinc();
    logic [7:0] d;
    io_write(16'h020A, 8'h9F);
    io_write(16'h0208, 8'h09);
    io_read(16'h020A, d); check("R6 lo no step", 32'(d), 32'h9F);
    io_write(16'h0209, 8'h80);
    io_read(16'h020A, d); check("R6 wrap", 32'(d), 32'h80);
    probe(24'h0E_C000, "R6 entry31 written", 24'h02_4000, 1'b1, 1'b0);
    io_write(16'h020A, 8'hE4);
    io_write(16'h0209, 8'h03);
    io_read(16'h020A, d); check("R6 step keeps top", 32'(d), 32'hE5);
    io_write(16'h020A, 8'h05);
    io_write(16'h0209, 8'h03);
    io_read(16'h020A, d); check("R6 no step bit7 clear", 32'(d), 32'h05);
  endtask

  task automatic t_idle();
    @(negedge clk);
    io_addr = 16'h020A; io_rd = 1'b0;
    #1 check("R11 idle read", 32'(io_rdata), 32'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ports();
    t_entry();
    t_xlate();
    t_miss();
    t_autoinc();
    t_idle();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule